// File: doc/BRIEF.md
# Quad SPI Flash Command Engine

This block runs one serial NOR flash command at a time on a four-lane SPI bus. The host first loads a 32-bit flash address into an address register. It then writes a command word that carries the flash opcode, a byte count, where the data sits in a local 256-byte buffer, whether that buffer is used, how many address bytes to send and the transfer direction. The engine asserts chip select and sends the opcode on one lane. It then sends the address, idles the bus for any dummy clocks and runs the data phase on one or four lanes. Finally it releases chip select.

Bulk data (page reads and page programs) moves between the flash and a word-wide buffer, which the host fills or drains through its own port. Short register reads (status, identification, configuration) land in a 32-bit readback register. The status output `eng_busy` is high from the cycle after a command is accepted until the bus has gone idle again. The SPI clock runs at half the system clock, with each SPI clock taking one system cycle low and then one high.

Top module: `qspi_cmd_engine`

## Requirements
- R1: After reset `eng_busy` is 0, `spi_cs_n` is 1, `spi_sck` is 0, `spi_io_oe` is 0 and `readback` is 0.
- R2: A write with `reg_wr_sel`=1 while idle is accepted and raises `eng_busy` on the next cycle. The command word is opcode [31:24], byte count [23:16], buffer base in 16-byte units [7:4], buffer enable [3], address-size code [2:1] and write direction [0]. A write with `reg_wr_sel`=0 loads the address register.
- R3: `spi_cs_n` stays low for exactly 2 cycles per SPI clock of a command. It is then high for 2 cycles before `eng_busy` falls, so `eng_busy` lasts 2·N+2 cycles for N SPI clocks.
- R4: Each SPI clock is one cycle with `spi_sck` low followed by one cycle high. Outputs change only while `spi_sck` is low, and input is sampled at the end of the high cycle. `spi_sck` is 0 whenever `spi_cs_n` is 1.
- R5: The opcode goes out most significant bit first on lane 0 over 8 SPI clocks, with `spi_io_oe`=0001.
- R6: Address-size code 2 sends address bits [23:0] and code 3 sends all 32 bits, most significant bit first. Codes 0 and 1 send no address.
- R7: Opcode 0xEB sends the address and data on four lanes, high nibble first. Opcode 0x6B sends the address on one lane and data on four. Opcode 0x32 sends data on four lanes. Opcodes 0xEB, 0x6B and 0x0B insert 10 dummy clocks with `spi_io_oe`=0. All other opcodes use one lane and no dummy clocks, with read data taken from lane 1.
- R8: With the buffer disabled, a read collects its first 4 bytes into `readback`, byte k in bits [8k+7:8k]. Later bytes are clocked but dropped. `readback` is cleared when a command is accepted.
- R9: With the buffer enabled, a byte count of 0 means 256 bytes. Read byte k is stored at buffer byte address (16·base + k) mod 256, where byte address a lies in word a/4 at bits [8(a mod 4)+7:8(a mod 4)].
- R10: A buffer-enabled write drives byte k from the same buffer position, most significant bit first, with `spi_io_oe`=0001 on one lane or 1111 on four.
- R11: With the buffer disabled, a byte count of 0 gives no data phase. A write then drives byte k from address-register bits [8(k mod 4)+7:8(k mod 4)].
- R12: Writes to either register while `eng_busy` is 1 are ignored.
- R13: A host buffer write stores `ram_wdata` at word `ram_addr`, and `ram_rdata` shows the word at `ram_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = address register, 1 = command word |
| reg_wr_data | input | 32 | Register write data |
| eng_busy | output | 1 | Command in progress |
| readback | output | 32 | Bytes gathered by a buffer-less read |
| ram_we | input | 1 | Host buffer write enable |
| ram_addr | input | 6 | Host buffer word address |
| ram_wdata | input | 32 | Host buffer write data |
| ram_rdata | output | 32 | Host buffer read data, one cycle latency |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_out | output | 4 | Output value of the four data lanes |
| spi_io_oe | output | 4 | Output enable of the four data lanes |
| spi_io_in | input | 4 | Input value of the four data lanes |

## Verification
A command write presented before edge P0 shows `eng_busy` just after P0. The bench checks it at the following falling clock edge. Bus results are tied to SPI clock numbers, not to cycles. A flash model counts `spi_sck` rising edges at falling system edges. It records lanes and enables for edge n, and it drives the response for edge n while `spi_sck` is low, so data is stable at the sampling edge. A command of N SPI clocks must end after 2·N+2 busy cycles with 2·N cycles of chip select low. Readback and buffer contents are compared only after `eng_busy` falls, and buffer words are read with the one-cycle port latency.

// File: rtl/qspi_eng_pkg.sv
package qspi_eng_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_DUMMY,
        S_DATA,
        S_GAP
    } phase_e;

    typedef struct packed {
        logic       addr_quad;
        logic       data_quad;
        logic [3:0] dummy;
    } op_mode_t;

    localparam int unsigned FAST_DUMMY = 10;

    function automatic op_mode_t decode_op(input logic [7:0] op);
        op_mode_t m;
        m = '{addr_quad: 1'b0, data_quad: 1'b0, dummy: 4'd0};
        case (op)
            8'hEB: m = '{addr_quad: 1'b1, data_quad: 1'b1, dummy: 4'(FAST_DUMMY)};
            8'h6B: m = '{addr_quad: 1'b0, data_quad: 1'b1, dummy: 4'(FAST_DUMMY)};
            8'h0B: m = '{addr_quad: 1'b0, data_quad: 1'b0, dummy: 4'(FAST_DUMMY)};
            8'h32: m = '{addr_quad: 1'b0, data_quad: 1'b1, dummy: 4'd0};
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic [2:0] addr_bytes(input logic [1:0] code);
        case (code)
            2'd2:    return 3'd3;
            2'd3:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/qspi_word_ram.sv
module qspi_word_ram #(
    parameter int unsigned WORDS = 64,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic          eng_we,
    input  logic [3:0]    eng_be,
    input  logic [AW-1:0] eng_waddr,
    input  logic [31:0]   eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [31:0]   eng_rdata
);

    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic [7:0] rd_q;

        always_ff @(posedge clk) begin
            if (eng_we && eng_be[b]) begin
                mem[eng_waddr] <= eng_wdata[8*b +: 8];
            end else if (host_we) begin
                mem[host_addr] <= host_wdata[8*b +: 8];
            end
            rd_q <= mem[host_addr];
        end

        assign host_rdata[8*b +: 8] = rd_q;
        assign eng_rdata[8*b +: 8]  = mem[eng_raddr];
    end

endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
    import qspi_eng_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 256,
    localparam int unsigned RB_W     = $clog2(RAM_BYTES),
    localparam int unsigned WA_W     = RB_W - 2,
    localparam int unsigned BASE_W   = RB_W - 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [31:0]     cmd_i,
    input  logic [31:0]     addr_i,
    output logic            busy_o,
    output logic [31:0]     readback_o,
    output logic            sck_o,
    output logic            cs_n_o,
    output logic [3:0]      io_out_o,
    output logic [3:0]      io_oe_o,
    input  logic [3:0]      io_in_i,
    output logic            ram_we_o,
    output logic [3:0]      ram_be_o,
    output logic [WA_W-1:0] ram_waddr_o,
    output logic [31:0]     ram_wdata_o,
    output logic [WA_W-1:0] ram_raddr_o,
    input  logic [31:0]     ram_rdata_i
);

    typedef struct packed {
        phase_e            st;
        logic              ph;
        logic              sck;
        logic              cs_n;
        logic [5:0]        cnt;
        logic [2:0]        bitc;
        logic [8:0]        left;
        logic [7:0]        k;
        logic [31:0]       osr;
        logic [7:0]        isr;
        logic [31:0]       rb;
        logic [31:0]       addr;
        logic [BASE_W-1:0] base;
        logic              ram_en;
        logic              wr;
        logic [2:0]        abytes;
        logic              aq;
        logic              dq;
        logic [3:0]        dummy;
        logic [8:0]        len;
    } seq_t;

    seq_t q, d;

    logic [7:0]      isr_n;
    logic [7:0]      nk;
    logic [RB_W-1:0] rd_ba;
    logic [RB_W-1:0] wr_ba;
    logic [7:0]      wbyte;
    logic            advance;
    phase_e          tgt;
    logic            we_c;
    op_mode_t        mode_n;

    assign isr_n  = q.dq ? {q.isr[3:0], io_in_i} : {q.isr[6:0], io_in_i[1]};
    assign nk     = (q.st == S_DATA) ? q.k + 8'd1 : 8'd0;
    assign rd_ba  = {q.base, 4'b0000} + nk[RB_W-1:0];
    assign wr_ba  = {q.base, 4'b0000} + q.k[RB_W-1:0];
    assign wbyte  = q.ram_en ? ram_rdata_i[8*rd_ba[1:0] +: 8] : q.addr[8*nk[1:0] +: 8];
    assign mode_n = decode_op(cmd_i[31:24]);

    always_comb begin
        d       = q;
        advance = 1'b0;
        tgt     = S_GAP;
        we_c    = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (go_i) begin
                    d.st     = S_CMD;
                    d.ph     = 1'b0;
                    d.sck    = 1'b0;
                    d.cs_n   = 1'b0;
                    d.cnt    = 6'd7;
                    d.osr    = {cmd_i[31:24], 24'h0};
                    d.rb     = '0;
                    d.addr   = addr_i;
                    d.base   = cmd_i[4 +: BASE_W];
                    d.ram_en = cmd_i[3];
                    d.wr     = cmd_i[0];
                    d.abytes = addr_bytes(cmd_i[2:1]);
                    d.aq     = mode_n.addr_quad;
                    d.dq     = mode_n.data_quad;
                    d.dummy  = mode_n.dummy;
                    if (cmd_i[23:16] == 8'd0) begin
                        d.len = cmd_i[3] ? 9'd256 : 9'd0;
                    end else begin
                        d.len = {1'b0, cmd_i[23:16]};
                    end
                end
            end
            S_GAP: begin
                d.ph = ~q.ph;
                if (q.ph) begin
                    d.st = S_IDLE;
                end
            end
            default: begin
                if (!q.ph) begin
                    d.ph  = 1'b1;
                    d.sck = 1'b1;
                end else begin
                    d.ph  = 1'b0;
                    d.sck = 1'b0;
                    if (q.st == S_DATA) begin
                        d.isr = isr_n;
                        d.osr = q.dq ? q.osr << 4 : q.osr << 1;
                        if (q.bitc != 3'd0) begin
                            d.bitc = q.bitc - 3'd1;
                        end else begin
                            if (!q.wr) begin
                                if (q.ram_en) begin
                                    we_c = 1'b1;
                                end else if (q.k[7:2] == 6'd0) begin
                                    d.rb[8*q.k[1:0] +: 8] = isr_n;
                                end
                            end
                            if (q.left == 9'd1) begin
                                advance = 1'b1;
                                tgt     = S_GAP;
                            end else begin
                                d.left = q.left - 9'd1;
                                d.k    = q.k + 8'd1;
                                d.bitc = q.dq ? 3'd1 : 3'd7;
                                d.osr  = {wbyte, 24'h0};
                            end
                        end
                    end else if (q.cnt != 6'd0) begin
                        d.cnt = q.cnt - 6'd1;
                        d.osr = (q.st == S_ADDR && q.aq) ? q.osr << 4 : q.osr << 1;
                    end else begin
                        advance = 1'b1;
                        if (q.st == S_CMD && q.abytes != 3'd0) begin
                            tgt = S_ADDR;
                        end else if (q.st != S_DUMMY && q.dummy != 4'd0) begin
                            tgt = S_DUMMY;
                        end else if (q.len != 9'd0) begin
                            tgt = S_DATA;
                        end else begin
                            tgt = S_GAP;
                        end
                    end
                end
            end
        endcase

        if (advance) begin
            d.st = tgt;
            case (tgt)
                S_ADDR: begin
                    d.cnt = q.aq ? {2'b00, q.abytes, 1'b0} - 6'd1
                                 : {q.abytes, 3'b000} - 6'd1;
                    d.osr = (q.abytes == 3'd4) ? q.addr : {q.addr[23:0], 8'h00};
                end
                S_DUMMY: begin
                    d.cnt = {2'b00, q.dummy} - 6'd1;
                end
                S_DATA: begin
                    d.k    = 8'd0;
                    d.left = q.len;
                    d.bitc = q.dq ? 3'd1 : 3'd7;
                    d.osr  = {wbyte, 24'h0};
                end
                default: begin
                    d.cs_n = 1'b1;
                    d.sck  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    logic quad_now;
    assign quad_now    = (q.st == S_ADDR && q.aq) || (q.st == S_DATA && q.dq);
    assign busy_o      = (q.st != S_IDLE);
    assign readback_o  = q.rb;
    assign sck_o       = q.sck;
    assign cs_n_o      = q.cs_n;
    assign io_out_o    = quad_now ? q.osr[31:28] : {3'b000, q.osr[31]};
    always_comb begin
        case (q.st)
            S_CMD:   io_oe_o = 4'b0001;
            S_ADDR:  io_oe_o = q.aq ? 4'b1111 : 4'b0001;
            S_DATA:  io_oe_o = q.wr ? (q.dq ? 4'b1111 : 4'b0001) : 4'b0000;
            default: io_oe_o = 4'b0000;
        endcase
    end
    assign ram_we_o    = we_c;
    assign ram_be_o    = 4'b0001 << wr_ba[1:0];
    assign ram_waddr_o = wr_ba[RB_W-1:2];
    assign ram_wdata_o = {4{isr_n}};
    assign ram_raddr_o = rd_ba[RB_W-1:2];

    // R2
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o) |=> busy_o);
    // R3
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);
    // R3
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cs_n_o) && $past(cs_n_o, 2)));
    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);
    // R4
    sck_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sck_o) |=> !sck_o);
    // R7
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe_o == 4'b0000 || io_oe_o == 4'b0001 || io_oe_o == 4'b1111));
    // R9
    ram_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (busy_o && !cs_n_o));

endmodule

// File: rtl/qspi_cmd_engine.sv
module qspi_cmd_engine #(
    parameter int unsigned RAM_BYTES = 256,
    localparam int unsigned RAM_WORDS = RAM_BYTES / 4,
    localparam int unsigned WA_W      = $clog2(RAM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic            reg_wr_sel,
    input  logic [31:0]     reg_wr_data,
    output logic            eng_busy,
    output logic [31:0]     readback,
    input  logic            ram_we,
    input  logic [WA_W-1:0] ram_addr,
    input  logic [31:0]     ram_wdata,
    output logic [31:0]     ram_rdata,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic [3:0]      spi_io_out,
    output logic [3:0]      spi_io_oe,
    input  logic [3:0]      spi_io_in
);

    logic [31:0]     addr_d, addr_q;
    logic            go;
    logic            e_we;
    logic [3:0]      e_be;
    logic [WA_W-1:0] e_waddr, e_raddr;
    logic [31:0]     e_wdata, e_rdata;

    assign go = reg_wr_en && reg_wr_sel && !eng_busy;

    always_comb begin
        addr_d = addr_q;
        if (reg_wr_en && !reg_wr_sel && !eng_busy) begin
            addr_d = reg_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    qspi_phase_seq #(.RAM_BYTES(RAM_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .cmd_i       (reg_wr_data),
        .addr_i      (addr_q),
        .busy_o      (eng_busy),
        .readback_o  (readback),
        .sck_o       (spi_sck),
        .cs_n_o      (spi_cs_n),
        .io_out_o    (spi_io_out),
        .io_oe_o     (spi_io_oe),
        .io_in_i     (spi_io_in),
        .ram_we_o    (e_we),
        .ram_be_o    (e_be),
        .ram_waddr_o (e_waddr),
        .ram_wdata_o (e_wdata),
        .ram_raddr_o (e_raddr),
        .ram_rdata_i (e_rdata)
    );

    qspi_word_ram #(.WORDS(RAM_WORDS)) u_ram (
        .clk        (clk),
        .host_we    (ram_we),
        .host_addr  (ram_addr),
        .host_wdata (ram_wdata),
        .host_rdata (ram_rdata),
        .eng_we     (e_we),
        .eng_be     (e_be),
        .eng_waddr  (e_waddr),
        .eng_wdata  (e_wdata),
        .eng_raddr  (e_raddr),
        .eng_rdata  (e_rdata)
    );

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(addr_q));

endmodule

// File: tb/qspi_cmd_engine_test.sv
module qspi_cmd_engine_test;

    localparam int MAXE = 2200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        eng_busy;
    logic [31:0] readback;
    logic        ram_we = 1'b0;
    logic [5:0]  ram_addr = '0;
    logic [31:0] ram_wdata = '0;
    logic [31:0] ram_rdata;
    logic        spi_sck, spi_cs_n;
    logic [3:0]  spi_io_out, spi_io_oe;
    logic [3:0]  spi_io_in = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [3:0] rec_out [MAXE];
    logic [3:0] rec_oe  [MAXE];
    logic [3:0] resp    [MAXE];
    int  n_edges = 0;
    int  busy_cnt = 0;
    int  cs_low_cnt = 0;
    logic prev_sck = 1'b0;

    always #10 clk = ~clk;

    qspi_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .eng_busy(eng_busy), .readback(readback),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
        .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    // flash model and cycle counters, all at falling clock edges
    initial begin
        forever begin
            @(negedge clk);
            if (eng_busy) busy_cnt++;
            if (!spi_cs_n) cs_low_cnt++;
            if (spi_sck && !prev_sck) begin
                if (n_edges < MAXE) begin
                    rec_out[n_edges] = spi_io_out;
                    rec_oe[n_edges]  = spi_io_oe;
                end
                n_edges++;
            end
            if (!spi_sck) spi_io_in = (n_edges < MAXE) ? resp[n_edges] : 4'h0;
            prev_sck = spi_sck;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [7:0] cnt,
                                       input logic [3:0] base, input logic ram_en,
                                       input logic [1:0] asz, input logic wr);
        return {op, cnt, 8'h00, base, ram_en, asz, wr};
    endfunction

    task automatic clear_resp();
        for (int i = 0; i < MAXE; i++) resp[i] = 4'h0;
    endtask

    task automatic put_byte(input int e, input logic [7:0] b, input logic quad);
        if (quad) begin
            resp[e]     = b[7:4];
            resp[e + 1] = b[3:0];
        end else begin
            for (int i = 0; i < 8; i++) resp[e + i] = {2'b00, b[7 - i], 1'b0};
        end
    endtask

    function automatic logic [7:0] sent_byte(input int e, input logic quad);
        logic [7:0] v;
        if (quad) v = {rec_out[e], rec_out[e + 1]};
        else for (int i = 0; i < 8; i++) v[7 - i] = rec_out[e + i][0];
        return v;
    endfunction

    task automatic start_cmd(input logic do_addr, input logic [31:0] a, input logic [31:0] c);
        if (do_addr) begin
            @(negedge clk);
            reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = a;
        end
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_data = c;
        n_edges = 0; busy_cnt = 0; cs_low_cnt = 0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R2 busy after accept", 32'(eng_busy), 32'd1);
    endtask

    task automatic wait_done(input int exp_edges);
        int lim;
        lim = 0;
        while (eng_busy && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        check("R3 command finished", 32'(eng_busy), 32'd0);
        check("R4 SPI clock count", n_edges, exp_edges);
        check("R3 busy cycles", busy_cnt, 2 * exp_edges + 2);
        check("R3 cs low cycles", cs_low_cnt, 2 * exp_edges);
    endtask

    task automatic chk_opcode(input logic [7:0] op);
        check("R5 opcode", 32'(sent_byte(0, 1'b0)), 32'(op));
        for (int i = 0; i < 8; i++) check("R5 opcode oe", 32'(rec_oe[i]), 32'h1);
    endtask

    task automatic ram_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        ram_addr = a;
        @(negedge clk);
        v = ram_rdata;
    endtask

    task automatic ram_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        ram_we = 1'b1; ram_addr = a; ram_wdata = v;
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    function automatic logic [7:0] fpat(input int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    task automatic t_reset();
        check("R1 busy", 32'(eng_busy), 32'd0);
        check("R1 cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 sck", 32'(spi_sck), 32'd0);
        check("R1 oe", 32'(spi_io_oe), 32'd0);
        check("R1 readback", readback, 32'd0);
    endtask

    task automatic t_wren();
        clear_resp();
        start_cmd(1'b1, 32'h0, mk(8'h06, 8'd0, 4'd0, 1'b0, 2'd0, 1'b0));
        wait_done(8);
        chk_opcode(8'h06);
        check("R11 no data phase readback", readback, 32'h0);
    endtask

    task automatic t_rdsr();
        clear_resp();
        put_byte(8, 8'hA5, 1'b0);
        start_cmd(1'b0, 32'h0, mk(8'h05, 8'd1, 4'd0, 1'b0, 2'd0, 1'b0));
        wait_done(16);
        chk_opcode(8'h05);
        check("R8 one byte readback", readback, 32'h0000_00A5);
        for (int i = 8; i < 16; i++) check("R8 read oe off", 32'(rec_oe[i]), 32'h0);
    endtask

    task automatic t_rdid();
        clear_resp();
        put_byte(8, 8'h20, 1'b0);  put_byte(16, 8'hBA, 1'b0);
        put_byte(24, 8'h19, 1'b0); put_byte(32, 8'h10, 1'b0);
        put_byte(40, 8'hFF, 1'b0); put_byte(48, 8'h77, 1'b0);
        start_cmd(1'b0, 32'h0, mk(8'h9F, 8'd6, 4'd0, 1'b0, 2'd0, 1'b0));
        wait_done(56);
        check("R8 first four bytes kept", readback, 32'h1019_BA20);
    endtask

    task automatic t_quad_read();
        logic [31:0] v;
        clear_resp();
        for (int k = 0; k < 8; k++) put_byte(24 + 2 * k, 8'(8'h11 * (k + 1)), 1'b1);
        start_cmd(1'b1, 32'h0012_3456, mk(8'hEB, 8'd8, 4'd2, 1'b1, 2'd2, 1'b0));
        wait_done(40);
        chk_opcode(8'hEB);
        for (int i = 0; i < 6; i++) begin
            check("R7 quad address nibble", 32'(rec_out[8 + i]), 32'(i + 1));
            check("R7 quad address oe", 32'(rec_oe[8 + i]), 32'hF);
        end
        for (int i = 14; i < 24; i++) check("R7 dummy oe off", 32'(rec_oe[i]), 32'h0);
        ram_read(6'd8, v); check("R9 quad read word 8", v, 32'h4433_2211);
        ram_read(6'd9, v); check("R9 quad read word 9", v, 32'h8877_6655);
    endtask

    task automatic t_page_read();
        logic [31:0] v;
        clear_resp();
        for (int k = 0; k < 256; k++) put_byte(50 + 8 * k, fpat(k), 1'b0);
        start_cmd(1'b1, 32'hDEAD_BEEF, mk(8'h0B, 8'd0, 4'd0, 1'b1, 2'd3, 1'b0));
        wait_done(2098);
        check("R6 four-byte address", {sent_byte(8, 1'b0), sent_byte(16, 1'b0),
              sent_byte(24, 1'b0), sent_byte(32, 1'b0)}, 32'hDEAD_BEEF);
        for (int i = 40; i < 50; i++) check("R7 single-lane dummy oe off", 32'(rec_oe[i]), 32'h0);
        for (int w = 0; w < 64; w++) begin
            ram_read(6'(w), v);
            check("R9 count zero full page", v,
                  {fpat(4 * w + 3), fpat(4 * w + 2), fpat(4 * w + 1), fpat(4 * w)});
        end
    endtask

    task automatic t_program();
        logic [7:0] ba;
        clear_resp();
        for (int w = 0; w < 64; w++)
            ram_write(6'(w), {8'(4 * w + 3), 8'(4 * w + 2), 8'(4 * w + 1), 8'(4 * w)} ^ 32'h5A5A_5A5A);
        start_cmd(1'b1, 32'h00AB_CDEF, mk(8'h02, 8'd20, 4'd15, 1'b1, 2'd2, 1'b1));
        wait_done(192);
        check("R6 three-byte address", {8'h00, sent_byte(8, 1'b0), sent_byte(16, 1'b0),
              sent_byte(24, 1'b0)}, 32'h00AB_CDEF);
        for (int k = 0; k < 20; k++) begin
            ba = 8'(240 + k);
            check("R10 program byte with wrap", 32'(sent_byte(32 + 8 * k, 1'b0)), 32'(ba ^ 8'h5A));
        end
        check("R10 single-lane oe", 32'(rec_oe[100]), 32'h1);
    endtask

    task automatic t_quad_program();
        clear_resp();
        start_cmd(1'b1, 32'h0, mk(8'h32, 8'd4, 4'd1, 1'b1, 2'd2, 1'b1));
        wait_done(40);
        for (int k = 0; k < 4; k++) begin
            check("R7 quad program byte", 32'(sent_byte(32 + 2 * k, 1'b1)), 32'(8'(16 + k) ^ 8'h5A));
            check("R10 quad oe", 32'(rec_oe[32 + 2 * k]), 32'hF);
        end
    endtask

    task automatic t_reg_write();
        clear_resp();
        start_cmd(1'b1, 32'h0000_C33C, mk(8'h01, 8'd2, 4'd0, 1'b0, 2'd0, 1'b1));
        wait_done(24);
        check("R11 first byte from address reg", 32'(sent_byte(8, 1'b0)), 32'h3C);
        check("R11 second byte from address reg", 32'(sent_byte(16, 1'b0)), 32'hC3);
    endtask

    task automatic t_ignore_busy();
        int cs_seen;
        clear_resp();
        put_byte(8, 8'h01, 1'b0);
        start_cmd(1'b1, 32'h0012_3ABC, mk(8'h05, 8'd3, 4'd0, 1'b0, 2'd0, 1'b0));
        repeat (4) @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_wr_sel = 1'b1; reg_wr_data = mk(8'h06, 8'd0, 4'd0, 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        reg_wr_en = 1'b0;
        wait_done(32);
        cs_seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (eng_busy || !spi_cs_n) cs_seen++;
        end
        check("R12 command while busy ignored", cs_seen, 0);
        start_cmd(1'b0, 32'h0, mk(8'h20, 8'd0, 4'd0, 1'b0, 2'd2, 1'b0));
        wait_done(32);
        check("R12 address write while busy ignored", {8'h00, sent_byte(8, 1'b0),
              sent_byte(16, 1'b0), sent_byte(24, 1'b0)}, 32'h0012_3ABC);
    endtask

    task automatic t_code_one();
        clear_resp();
        start_cmd(1'b1, 32'h0055_6677, mk(8'h20, 8'd0, 4'd0, 1'b0, 2'd1, 1'b0));
        wait_done(8);
        chk_opcode(8'h20);
    endtask

    task automatic t_host_ram();
        logic [31:0] v;
        ram_write(6'd63, 32'hCAFE_F00D);
        ram_read(6'd63, v);
        check("R13 host buffer readback", v, 32'hCAFE_F00D);
        ram_write(6'd0, 32'h1234_5678);
        ram_read(6'd0, v);
        check("R13 host buffer word 0", v, 32'h1234_5678);
    endtask

    initial begin
        clear_resp();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_wren();
        t_rdsr();
        t_rdid();
        t_quad_read();
        t_page_read();
        t_program();
        t_quad_program();
        t_reg_write();
        t_ignore_busy();
        t_code_one();
        t_host_ram();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule